// File: doc/BRIEF.md
# Multiphase Oversampled Frame Synchroniser

This block recovers framed data from a single serial line that has been sampled at four evenly spaced phases per bit period. All four samples of one bit period arrive together on every system clock. While the block is hunting for a frame, it watches for the first zero-to-one transition among the samples. The position of that transition picks a sampling phase two quarter-periods later, which is the phase farthest from the edge. The phase is fixed in the same clock as the edge, so the choice is complete long before the 16-bit sync word has passed.

From that point on, one bit per bit period is taken from the chosen phase. The first 16 bits are compared with a programmable sync word. A match produces a one-cycle sync pulse, and the block then packs the payload into parallel words, first bit received in the most significant position, until the programmed number of words has been delivered. A mismatch returns the block to hunting and no data is emitted. A line held low for at least one bit period always separates frames.

Top module: `frame_sync_rx`

## Requirements
- R1: A synchronous active-high reset returns the block to hunting and clears `data_vld_o`, `sync_found_o` and `phase_o` (to 0) on the next clock.
- R2: `smp_i[j]` is the sample at phase j, where phase 0 is the earliest and the previous period's phase 3 comes just before it. If k is the earliest phase whose sample is 1 while the sample before it is 0, then the chosen phase is (k+2) mod 4. `phase_o` shows this phase and stays constant while payload words are emitted.
- R3: The 16 sync bits are read on the chosen phase. The first bit comes from the period of the edge when k is 0 or 1, and from the following period when k is 2 or 3. The bits are compared with `sync_pat_i`, bit 15 first. On a match, `sync_found_o` is high for exactly one cycle: the cycle after the one that carried the 16th sync bit.
- R4: If the 16 bits differ from `sync_pat_i` in any position, no sync pulse and no data word are produced, and the block resumes hunting.
- R5: After a match, each group of 8 consecutive bits from the chosen phase forms one word, with the earliest bit in bit 7. The word appears on `data_o` with `data_vld_o` high for one cycle, and `data_vld_o` is never high in the same cycle as `sync_found_o`.
- R6: Exactly `frame_words_i` words are emitted per matched frame, after which the block hunts again. A value of 0 gives the sync pulse but no words.
- R7: Zero-to-one transitions inside the sync word or the payload never restart the search. A second frame that follows after a single zero bit is found and fully recovered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, one bit period per cycle |
| rst | input | 1 | Synchronous active-high reset |
| smp_i | input | 4 | Four phase samples of the current bit period, bit 0 earliest |
| sync_pat_i | input | 16 | Expected sync word, bit 15 received first |
| frame_words_i | input | 8 | Number of payload words per frame |
| data_o | output | 8 | Recovered payload word |
| data_vld_o | output | 1 | One-cycle strobe qualifying `data_o` |
| sync_found_o | output | 1 | One-cycle pulse on a matched sync word |
| phase_o | output | 2 | Index of the selected sampling phase |

## Verification
The case that is hardest to reach is an edge in phase 2 or 3. There the chosen phase lands in the next clock period, so the sync word and every payload bit straddle two input vectors. The bench reaches this case by building each frame as a bit list and slicing it into four-sample vectors with a programmable offset. Every table entry then places the edge at a chosen phase, and the latency of the sync pulse is checked against that offset. The same slicer also drives two frames separated by one zero bit, and it applies a reset in the middle of a frame's payload.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    localparam int PH_N = 4;
    localparam int PH_W = $clog2(PH_N);

    typedef enum logic [1:0] {
        ST_SEARCH     = 2'd0,
        ST_SYNC_CHECK = 2'd1,
        ST_DATA       = 2'd2
    } fsr_state_e;

    // Result of scanning one period of phase samples for a rising edge.
    typedef struct packed {
        logic            hit;   // a 0->1 transition was seen
        logic            late;  // chosen phase falls in the next period
        logic [PH_W-1:0] pick;  // phase two quarter-periods after the edge
    } edge_info_t;

    // Earliest rising transition wins; ext[0] is the last sample of the
    // previous period so an edge right at phase 0 is also caught.
    function automatic edge_info_t locate_edge(input logic prev,
                                               input logic [PH_N-1:0] s);
        edge_info_t      r;
        logic [PH_N:0]   ext;
        r   = '0;
        ext = {s, prev};
        for (int k = 0; k < PH_N; k++) begin
            if (!r.hit && ext[k+1] && !ext[k]) begin
                r.hit  = 1'b1;
                r.late = (k >= PH_N / 2);
                r.pick = PH_W'((k + PH_N / 2) % PH_N);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/fsr_edge_finder.sv
module fsr_edge_finder
    import fsr_pkg::*;
(
    input  logic            prev_i,
    input  logic [PH_N-1:0] smp_i,
    output edge_info_t      info_o
);
    assign info_o = locate_edge(prev_i, smp_i);
endmodule

// File: rtl/fsr_phase_tap.sv
module fsr_phase_tap
    import fsr_pkg::*;
(
    input  logic [PH_N-1:0] smp_i,
    input  logic [PH_W-1:0] sel_i,
    output logic            bit_o
);
    assign bit_o = smp_i[sel_i];
endmodule

// File: rtl/fsr_framer.sv
module fsr_framer
    import fsr_pkg::*;
#(
    parameter int SYNC_W = 16,
    parameter int WORD_W = 8,
    parameter int FLEN_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  edge_info_t        edge_i,
    input  logic              tap_cur_i,   // sample on the held phase
    input  logic              tap_new_i,   // sample on the phase just picked
    input  logic [SYNC_W-1:0] sync_pat_i,
    input  logic [FLEN_W-1:0] frame_words_i,
    output logic [PH_W-1:0]   phase_o,
    output logic [WORD_W-1:0] data_o,
    output logic              data_vld_o,
    output logic              sync_found_o
);
    localparam int CNT_MAX = (SYNC_W > WORD_W) ? SYNC_W : WORD_W;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    fsr_state_e         st_q, st_n;
    logic [PH_W-1:0]    ph_q, ph_n;
    logic [CNT_W-1:0]   cnt_q, cnt_n;
    logic [SYNC_W-1:0]  sh_q, sh_n;
    logic [WORD_W-1:0]  word_q, word_n;
    logic [FLEN_W-1:0]  wcnt_q, wcnt_n;
    logic [WORD_W-1:0]  data_q, data_n;
    logic               vld_q, vld_n;
    logic               found_q, found_n;

    always_comb begin
        st_n    = st_q;
        ph_n    = ph_q;
        cnt_n   = cnt_q;
        sh_n    = sh_q;
        word_n  = word_q;
        wcnt_n  = wcnt_q;
        data_n  = data_q;
        vld_n   = 1'b0;
        found_n = 1'b0;
        unique case (st_q)
            ST_SEARCH: begin
                if (edge_i.hit) begin
                    st_n = ST_SYNC_CHECK;
                    ph_n = edge_i.pick;
                    if (edge_i.late) begin
                        sh_n  = '0;
                        cnt_n = '0;
                    end else begin
                        sh_n  = SYNC_W'(tap_new_i);
                        cnt_n = CNT_W'(1);
                    end
                end
            end
            ST_SYNC_CHECK: begin
                sh_n  = {sh_q[SYNC_W-2:0], tap_cur_i};
                cnt_n = CNT_W'(cnt_q + 1'b1);
                if (cnt_n == CNT_W'(SYNC_W)) begin
                    cnt_n = '0;
                    if (sh_n == sync_pat_i) begin
                        found_n = 1'b1;
                        wcnt_n  = '0;
                        word_n  = '0;
                        st_n    = (frame_words_i == '0) ? ST_SEARCH : ST_DATA;
                    end else begin
                        st_n = ST_SEARCH;
                    end
                end
            end
            ST_DATA: begin
                word_n = {word_q[WORD_W-2:0], tap_cur_i};
                cnt_n  = CNT_W'(cnt_q + 1'b1);
                if (cnt_n == CNT_W'(WORD_W)) begin
                    cnt_n  = '0;
                    data_n = word_n;
                    vld_n  = 1'b1;
                    wcnt_n = FLEN_W'(wcnt_q + 1'b1);
                    if (wcnt_n == frame_words_i) begin
                        st_n = ST_SEARCH;
                    end
                end
            end
            default: st_n = ST_SEARCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_SEARCH;
            ph_q    <= '0;
            cnt_q   <= '0;
            sh_q    <= '0;
            word_q  <= '0;
            wcnt_q  <= '0;
            data_q  <= '0;
            vld_q   <= 1'b0;
            found_q <= 1'b0;
        end else begin
            st_q    <= st_n;
            ph_q    <= ph_n;
            cnt_q   <= cnt_n;
            sh_q    <= sh_n;
            word_q  <= word_n;
            wcnt_q  <= wcnt_n;
            data_q  <= data_n;
            vld_q   <= vld_n;
            found_q <= found_n;
        end
    end

    assign phase_o      = ph_q;
    assign data_o       = data_q;
    assign data_vld_o   = vld_q;
    assign sync_found_o = found_q;
endmodule

// File: rtl/frame_sync_rx.sv
module frame_sync_rx
    import fsr_pkg::*;
#(
    parameter int SYNC_W = 16,
    parameter int WORD_W = 8,
    parameter int FLEN_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        smp_i,
    input  logic [SYNC_W-1:0] sync_pat_i,
    input  logic [FLEN_W-1:0] frame_words_i,
    output logic [WORD_W-1:0] data_o,
    output logic              data_vld_o,
    output logic              sync_found_o,
    output logic [1:0]        phase_o
);
    logic            last_q;
    edge_info_t      edge_w;
    logic [PH_W-1:0] ph_w;
    logic [1:0]      tap_w;
    logic [PH_W-1:0] sel_w [2];

    // Last phase of the previous period, needed to see an edge at phase 0.
    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= smp_i[PH_N-1];
    end

    fsr_edge_finder i_edge (
        .prev_i (last_q),
        .smp_i  (smp_i),
        .info_o (edge_w)
    );

    assign sel_w[0] = ph_w;
    assign sel_w[1] = edge_w.pick;

    // Tap 0 follows the held phase, tap 1 the phase being picked now.
    for (genvar g = 0; g < 2; g++) begin : g_tap
        fsr_phase_tap i_tap (
            .smp_i (smp_i),
            .sel_i (sel_w[g]),
            .bit_o (tap_w[g])
        );
    end

    fsr_framer #(
        .SYNC_W (SYNC_W),
        .WORD_W (WORD_W),
        .FLEN_W (FLEN_W)
    ) i_framer (
        .clk           (clk),
        .rst           (rst),
        .edge_i        (edge_w),
        .tap_cur_i     (tap_w[0]),
        .tap_new_i     (tap_w[1]),
        .sync_pat_i    (sync_pat_i),
        .frame_words_i (frame_words_i),
        .phase_o       (ph_w),
        .data_o        (data_o),
        .data_vld_o    (data_vld_o),
        .sync_found_o  (sync_found_o)
    );

    assign phase_o = ph_w;
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker (
    input logic       clk,
    input logic       rst,
    input logic       data_vld_o,
    input logic       sync_found_o,
    input logic [1:0] phase_o
);
    // R1: outputs quiet one clock after reset
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!data_vld_o && !sync_found_o && phase_o == 2'd0));

    // R3: the sync pulse lasts one cycle
    a_r3_found_single: assert property (@(posedge clk) disable iff (rst)
        sync_found_o |=> !sync_found_o);

    // R5: each word strobe lasts one cycle
    a_r5_vld_single: assert property (@(posedge clk) disable iff (rst)
        data_vld_o |=> !data_vld_o);

    // R5: word strobe and sync pulse never coincide
    a_r5_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(data_vld_o && sync_found_o));

    // R2: phase held while words are delivered
    a_r2_phase_held: assert property (@(posedge clk) disable iff (rst)
        data_vld_o |-> $stable(phase_o));
endmodule

bind frame_sync_rx fsr_checker i_fsr_checker (
    .clk          (clk),
    .rst          (rst),
    .data_vld_o   (data_vld_o),
    .sync_found_o (sync_found_o),
    .phase_o      (phase_o)
);

// File: tb/test_frame_sync_rx.sv
module test_frame_sync_rx;
    localparam int LEAD = 3;
    localparam int TAIL = 6;
    localparam int MAXB = 512;
    localparam int NVEC = 8;
    // fields: [23:22] edge phase, [21:14] words, [13:6] seed, [5] corrupt
    localparam logic [23:0] VEC [NVEC] = '{
        {2'd0, 8'd3, 8'd17, 1'b0, 5'd0},
        {2'd1, 8'd2, 8'd40, 1'b0, 5'd0},
        {2'd2, 8'd4, 8'd91, 1'b0, 5'd0},
        {2'd3, 8'd1, 8'd5,  1'b0, 5'd0},
        {2'd0, 8'd0, 8'd33, 1'b0, 5'd0},
        {2'd2, 8'd3, 8'd60, 1'b1, 5'd0},
        {2'd1, 8'd5, 8'd77, 1'b0, 5'd0},
        {2'd3, 8'd2, 8'd12, 1'b1, 5'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  smp = '0;
    logic [15:0] pat = 16'hB38E;
    logic [7:0]  fwords = '0;
    logic [7:0]  data_o;
    logic        data_vld_o;
    logic        sync_found_o;
    logic [1:0]  phase_o;

    always #10 clk = ~clk;

    frame_sync_rx i_frame_sync_rx (
        .clk           (clk),
        .rst           (rst),
        .smp_i         (smp),
        .sync_pat_i    (pat),
        .frame_words_i (fwords),
        .data_o        (data_o),
        .data_vld_o    (data_vld_o),
        .sync_found_o  (sync_found_o),
        .phase_o       (phase_o)
    );

    int         n_cmp = 0;
    int         n_bad = 0;
    int         drive_cyc = 0;
    bit         mon_en = 1'b0;
    int         found_n = 0;
    int         found_cyc = -1;
    logic [1:0] found_ph = '0;
    int         rx_n = 0;
    logic [7:0] rx [64];
    bit         sbits [MAXB];
    int         slen = 0;
    int         wd = 0;

    always @(negedge clk) begin
        if (mon_en) begin
            if (sync_found_o) begin
                found_n++;
                found_cyc = drive_cyc;
                found_ph  = phase_o;
            end
            if (data_vld_o && rx_n < 64) begin
                rx[rx_n] = data_o;
                rx_n++;
            end
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_bad++;
            $display("FAIL watchdog: run hung, actual=%0d expected<%0d", wd, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] wgen(input int seed, input int i);
        return 8'((seed * 37 + i * 53 + 11) & 255);
    endfunction

    task automatic add_bit(input bit b);
        sbits[slen] = b;
        slen++;
    endtask

    task automatic add_frame(input logic [15:0] p, input int nw, input int seed, input bit bad);
        logic [7:0] w;
        for (int i = 15; i >= 0; i--) add_bit(p[i]);
        if (bad) sbits[slen-16+5] = ~sbits[slen-16+5];
        for (int k = 0; k < nw; k++) begin
            w = wgen(seed, k);
            for (int i = 7; i >= 0; i--) add_bit(w[i]);
        end
    endtask

    task automatic start();
        mon_en = 1'b0;
        @(negedge clk); #1;
        rst = 1'b1;
        smp = '0;
        @(negedge clk); #1;
        rst = 1'b0;
        slen      = 0;
        found_n   = 0;
        found_cyc = -1;
        found_ph  = '0;
        rx_n      = 0;
        for (int i = 0; i < LEAD; i++) add_bit(1'b0);
    endtask

    // Slice the bit list into four-sample vectors, edge at phase 'off'.
    task automatic drive(input int off, input int rst_at);
        mon_en = 1'b1;
        for (int c = 0; c < slen + TAIL; c++) begin
            @(negedge clk); #1;
            drive_cyc = c;
            rst = (c == rst_at);
            for (int j = 0; j < 4; j++) begin
                int n;
                int b;
                n = 4 * c + j - off;
                b = (n < 0) ? -1 : n / 4;
                smp[j] = (b >= 0 && b < slen) ? sbits[b] : 1'b0;
            end
        end
        @(negedge clk); #1;
        rst = 1'b0;
        smp = '0;
        mon_en = 1'b0;
    endtask

    initial begin
        // R1: state during and right after power-up reset
        @(negedge clk);
        @(negedge clk);
        check(data_vld_o == 1'b0,   "R1 reset data_vld_o", data_vld_o, 0);
        check(sync_found_o == 1'b0, "R1 reset sync_found_o", sync_found_o, 0);
        check(phase_o == 2'd0,      "R1 reset phase_o", phase_o, 0);

        // Table walk: R2 phase, R3 latency, R4 mismatch, R5 words, R6 length
        for (int v = 0; v < NVEC; v++) begin
            int  off;
            int  nw;
            int  seed;
            bit  bad;
            off  = int'(VEC[v][23:22]);
            nw   = int'(VEC[v][21:14]);
            seed = int'(VEC[v][13:6]);
            bad  = VEC[v][5];
            start();
            fwords = 8'(nw);
            add_frame(pat, nw, seed, bad);
            drive(off, -1);
            if (bad) begin
                check(found_n == 0, "R4 no sync pulse on mismatch", found_n, 0);
                check(rx_n == 0,    "R4 no data on mismatch", rx_n, 0);
            end else begin
                check(found_n == 1, "R3 one sync pulse", found_n, 1);
                check(found_cyc == LEAD + 15 + ((off >= 2) ? 1 : 0),
                      "R3 sync pulse latency", found_cyc, LEAD + 15 + ((off >= 2) ? 1 : 0));
                check(int'(found_ph) == (off + 2) % 4, "R2 chosen phase", found_ph, (off + 2) % 4);
                check(rx_n == nw, "R6 word count", rx_n, nw);
                for (int k = 0; k < nw && k < rx_n; k++)
                    check(rx[k] == wgen(seed, k), "R5 payload word", rx[k], wgen(seed, k));
            end
        end

        // R7: two frames with one zero bit between, other sync word (R3)
        start();
        pat    = 16'hF0A5;
        fwords = 8'd2;
        add_frame(pat, 2, 9, 1'b0);
        add_bit(1'b0);
        add_frame(pat, 2, 20, 1'b0);
        drive(1, -1);
        check(found_n == 2, "R7 back-to-back sync pulses", found_n, 2);
        check(rx_n == 4,    "R7 back-to-back word count", rx_n, 4);
        if (rx_n == 4) begin
            check(rx[1] == wgen(9, 1),  "R7 first frame last word", rx[1], wgen(9, 1));
            check(rx[2] == wgen(20, 0), "R7 second frame first word", rx[2], wgen(20, 0));
        end
        check(found_ph == 2'd3, "R2 phase for edge at 1", found_ph, 3);

        // R1: reset in the middle of the payload stops the frame
        start();
        pat    = 16'hB38E;
        fwords = 8'd4;
        add_frame(pat, 4, 44, 1'b0);
        drive(0, 22);
        check(found_n == 1, "R1 sync before reset", found_n, 1);
        check(rx_n == 0,    "R1 no words after mid-frame reset", rx_n, 0);
        @(negedge clk);
        check(phase_o == 2'd0 || phase_o == 2'd2, "R1 phase after reset", phase_o, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule